// File: doc/BRIEF.md
# I2C Master Bus Sequencer

This block is a single-master I2C sequencer steered through one 16-bit control and status word. Software asks for a start condition, then queues byte transfers with separate transmit and receive request pulses, and finally asks for a stop condition. The block turns these requests into SCL and SDA activity on an open-drain bus. A bit-rate clock enable sets the pace. Every SCL half period lasts one enable interval.

Between bytes the sequencer holds SCL low in a wait state and accepts the next request. A start request always goes first, then a queued transmit, then a queued receive. A stop request only takes effect once nothing else is queued. Transmitted bytes go out MSB first, and the slave's ninth-bit answer is latched. For received bytes the master drives ACK or NACK, as chosen when the receive is requested. An optional deglitcher on the SDA and SCL inputs rejects pulses shorter than three system-clock samples. It is meant for bit rates of at most one sixth of the system clock.

Top module: `i2c_seq_ctrl`

## Requirements
- R1: The control word reads start request at bit 0, stop request at bit 1, input filter enable at bit 4, transmit busy at bit 8 and receive busy at bit 9. All other bits read 0, writes to bits 8 and 9 are ignored, and every bit is 0 after reset.
- R2: With the start bit set and both lines seen high, SDA is pulled low while SCL stays released, and the start bit then clears itself. From the wait state, a start request first releases SDA and then SCL, which gives a repeated start.
- R3: Transmit busy reads 1 only while a transmit byte with its ninth bit is on the bus. Receive busy reads 1 only while a receive byte is on the bus. Both read 0 in the wait state.
- R4: A transmit sends the 8 bits MSB first and then releases SDA for a ninth clock. At the end of that clock `slave_nack` takes the sampled SDA level (1 means NACK).
- R5: A receive shifts in 8 bits MSB first and presents them on `rx_byte` when the byte ends. On the ninth clock the master pulls SDA low if `rx_nack_sel` was 0 at request time, and releases it if it was 1.
- R6: A stop request waits while a start, transmit or receive request is pending. It starts only from the wait state once all three are clear, so queued bytes go out before the stop.
- R7: A stop takes SDA from low to high while SCL is released. Both lines are then released, and the stop bit clears itself.
- R8: With the filter enabled, an input level reaches the sequencer only after three consecutive equal system-clock samples, so a two-sample pulse on SDA or SCL has no effect.
- R9: After a start condition and after each byte, the sequencer holds SCL low until the next request is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data for the control word |
| reg_rdata | output | 16 | Current control and status word |
| tx_go | input | 1 | Pulse: queue a transmit byte |
| tx_byte | input | 8 | Byte captured on `tx_go` |
| rx_go | input | 1 | Pulse: queue a receive byte |
| rx_nack_sel | input | 1 | Captured on `rx_go`: 1 answers NACK, 0 answers ACK |
| bit_tick | input | 1 | Bit-rate enable, one per SCL half period |
| rx_byte | output | 8 | Last received byte |
| slave_nack | output | 1 | Ninth-bit level of the last transmit |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |

## Verification
The bench queues a stop while a transmit is on the bus and a second transmit is pending. A design that honoured the stop at once would put a stop between the two bytes, and the bus scoreboard would flag it. Receive bytes are sent while two-sample glitches are forced onto the sequencer's SDA input just before each sampling edge. A filter that was missing, bypassed or too short would flip bits of the received byte. Repeated starts, a NACK from the slave and a master NACK check the ninth-bit handling in both directions. Writing ones to the reserved and read-only bits catches bits that are not masked on read.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    localparam int CTL_W       = 16;
    localparam int POS_START   = 0;
    localparam int POS_STOP    = 1;
    localparam int POS_FILT    = 4;
    localparam int POS_TBUSY   = 8;
    localparam int POS_RBUSY   = 9;

    typedef enum logic [3:0] {
        E_IDLE,
        E_RS_REL,
        E_RS_HI,
        E_ST_LOW,
        E_ST_HOLD,
        E_WAIT,
        E_XFER,
        E_SP_LOW,
        E_SP_HI,
        E_SP_REL
    } eng_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC   = 2,
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic en,
    output logic level
);
    localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            filt;
        logic [CW-1:0]   cnt;
    } flt_t;

    flt_t d, q;
    logic in_s;

    assign in_s = q.sync[SYNC-1];

    always_comb begin
        d = q;
        d.sync = {q.sync[SYNC-2:0], raw};
        if (in_s == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(STABLE - 1)) begin
            d.filt = in_s;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.filt <= 1'b1;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign level = en ? q.filt : in_s;

    // R8: the filtered level only moves after three equal samples
    a_r8_three_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (q.filt != $past(q.filt)) |->
            ($past(in_s, 1) == q.filt && $past(in_s, 2) == q.filt && $past(in_s, 3) == q.filt));
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
    import i2c_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          tx_req,
    input  logic          rx_req,
    input  logic [DW-1:0] tx_data,
    input  logic          nack_sel,
    input  logic          sda_f,
    input  logic          scl_f,
    output logic          start_ack,
    output logic          stop_go,
    output logic          stop_done,
    output logic          tx_take,
    output logic          rx_take,
    output logic          tbusy,
    output logic          rbusy,
    output logic [DW-1:0] rx_data,
    output logic          ack_seen,
    output logic          sda_oe,
    output logic          scl_oe
);
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] LAST = BCW'(DW);

    typedef struct packed {
        eng_state_t     state;
        logic [BCW-1:0] bitn;
        logic           phase;
        logic           dir_rx;
        logic           nack;
        logic [DW-1:0]  shreg;
        logic [DW-1:0]  rx_hold;
        logic           ack_in;
        logic           sda_oe;
        logic           scl_oe;
    } eng_t;

    eng_t d, q;
    logic [DW-1:0] sh_next;

    always_comb begin
        d         = q;
        start_ack = 1'b0;
        stop_go   = 1'b0;
        stop_done = 1'b0;
        tx_take   = 1'b0;
        rx_take   = 1'b0;
        sh_next   = q.shreg;
        if (tick) begin
            unique case (q.state)
                E_IDLE: begin
                    if (start_req && sda_f && scl_f) begin
                        d.state   = E_ST_LOW;
                        d.sda_oe  = 1'b1;
                        start_ack = 1'b1;
                    end
                end
                E_WAIT: begin
                    if (start_req) begin
                        d.state  = E_RS_REL;
                        d.sda_oe = 1'b0;
                    end else if (tx_req) begin
                        d.state  = E_XFER;
                        d.dir_rx = 1'b0;
                        d.bitn   = '0;
                        d.phase  = 1'b0;
                        d.shreg  = tx_data;
                        d.sda_oe = !tx_data[DW-1];
                        tx_take  = 1'b1;
                    end else if (rx_req) begin
                        d.state  = E_XFER;
                        d.dir_rx = 1'b1;
                        d.bitn   = '0;
                        d.phase  = 1'b0;
                        d.nack   = nack_sel;
                        d.sda_oe = 1'b0;
                        rx_take  = 1'b1;
                    end else if (stop_req) begin
                        d.state  = E_SP_LOW;
                        d.sda_oe = 1'b1;
                        stop_go  = 1'b1;
                    end
                end
                E_RS_REL: begin
                    d.state  = E_RS_HI;
                    d.scl_oe = 1'b0;
                end
                E_RS_HI: begin
                    d.state   = E_ST_LOW;
                    d.sda_oe  = 1'b1;
                    start_ack = 1'b1;
                end
                E_ST_LOW: begin
                    d.state  = E_ST_HOLD;
                    d.scl_oe = 1'b1;
                end
                E_ST_HOLD: d.state = E_WAIT;
                E_XFER: begin
                    if (!q.phase) begin
                        d.phase  = 1'b1;
                        d.scl_oe = 1'b0;
                    end else begin
                        if (q.bitn != LAST) begin
                            sh_next = q.dir_rx ? {q.shreg[DW-2:0], sda_f}
                                               : {q.shreg[DW-2:0], 1'b0};
                        end else if (!q.dir_rx) begin
                            d.ack_in = sda_f;
                        end
                        d.shreg  = sh_next;
                        d.scl_oe = 1'b1;
                        if (q.bitn == LAST) begin
                            d.state = E_WAIT;
                            if (q.dir_rx) d.rx_hold = q.shreg;
                        end else begin
                            d.bitn  = q.bitn + 1'b1;
                            d.phase = 1'b0;
                            if (q.dir_rx)
                                d.sda_oe = (q.bitn == LAST - 1'b1) ? !q.nack : 1'b0;
                            else
                                d.sda_oe = (q.bitn == LAST - 1'b1) ? 1'b0 : !sh_next[DW-1];
                        end
                    end
                end
                E_SP_LOW: begin
                    d.state  = E_SP_HI;
                    d.scl_oe = 1'b0;
                end
                E_SP_HI: begin
                    d.state   = E_SP_REL;
                    d.sda_oe  = 1'b0;
                    stop_done = 1'b1;
                end
                E_SP_REL: d.state = E_IDLE;
                default:  d.state = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= E_IDLE;
            q.bitn    <= '0;
            q.phase   <= 1'b0;
            q.dir_rx  <= 1'b0;
            q.nack    <= 1'b0;
            q.shreg   <= '0;
            q.rx_hold <= '0;
            q.ack_in  <= 1'b0;
            q.sda_oe  <= 1'b0;
            q.scl_oe  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tbusy    = (q.state == E_XFER) && !q.dir_rx;
    assign rbusy    = (q.state == E_XFER) && q.dir_rx;
    assign rx_data  = q.rx_hold;
    assign ack_seen = q.ack_in;
    assign sda_oe   = q.sda_oe;
    assign scl_oe   = q.scl_oe;

    // R2: SDA is only pulled down under a released SCL when a start is made
    a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.scl_oe && !$past(q.scl_oe) && q.sda_oe && !$past(q.sda_oe)) |-> (q.state == E_ST_LOW));

    // R7: SDA is only released under a released SCL when a stop is made
    a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.scl_oe && !$past(q.scl_oe) && !q.sda_oe && $past(q.sda_oe)) |-> (q.state == E_SP_REL));

    // R3: the two busy flags never read 1 together
    a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbusy && rbusy));
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SYNC      = 2,
    parameter int FILT_LEN  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             tx_go,
    input  logic [DW-1:0]    tx_byte,
    input  logic             rx_go,
    input  logic             rx_nack_sel,
    input  logic             bit_tick,
    output logic [DW-1:0]    rx_byte,
    output logic             slave_nack,
    input  logic             sda_i,
    input  logic             scl_i,
    output logic             sda_oe,
    output logic             scl_oe
);
    localparam int NLINES = 2;

    typedef struct packed {
        logic          start;
        logic          stop;
        logic          filt;
        logic          tx_pend;
        logic          rx_pend;
        logic [DW-1:0] tx_data;
        logic          nack;
    } ctl_t;

    ctl_t d, q;
    logic start_ack, stop_go, stop_done, tx_take, rx_take, tbusy, rbusy;
    logic [NLINES-1:0] raw_lines, flt_lines;
    logic wdata_unused;

    assign wdata_unused = ^reg_wdata;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_filter #(.SYNC(SYNC), .STABLE(FILT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .en    (q.filt),
            .level (flt_lines[g])
        );
    end

    always_comb begin
        d = q;
        if (start_ack) d.start = 1'b0;
        if (stop_done) d.stop  = 1'b0;
        if (reg_wr) begin
            d.start = reg_wdata[POS_START];
            d.stop  = reg_wdata[POS_STOP];
            d.filt  = reg_wdata[POS_FILT];
        end
        if (tx_take) d.tx_pend = 1'b0;
        if (rx_take) d.rx_pend = 1'b0;
        if (tx_go) begin
            d.tx_pend = 1'b1;
            d.tx_data = tx_byte;
        end
        if (rx_go) begin
            d.rx_pend = 1'b1;
            d.nack    = rx_nack_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    i2c_seq_engine #(.DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .start_req (q.start),
        .stop_req  (q.stop),
        .tx_req    (q.tx_pend),
        .rx_req    (q.rx_pend),
        .tx_data   (q.tx_data),
        .nack_sel  (q.nack),
        .sda_f     (flt_lines[0]),
        .scl_f     (flt_lines[1]),
        .start_ack (start_ack),
        .stop_go   (stop_go),
        .stop_done (stop_done),
        .tx_take   (tx_take),
        .rx_take   (rx_take),
        .tbusy     (tbusy),
        .rbusy     (rbusy),
        .rx_data   (rx_byte),
        .ack_seen  (slave_nack),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe)
    );

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[POS_START] = q.start;
        reg_rdata[POS_STOP]  = q.stop;
        reg_rdata[POS_FILT]  = q.filt;
        reg_rdata[POS_TBUSY] = tbusy;
        reg_rdata[POS_RBUSY] = rbusy;
    end

    // R6: a stop only begins when nothing else is queued
    a_r6_stop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stop_go |-> (q.stop && !q.tx_pend && !q.rx_pend && !q.start));

    // R7: the stop bit drops after the stop condition unless rewritten
    a_r7_stop_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> (!q.stop || $past(reg_wr)));
endmodule

// File: tb/tb_i2c_seq_ctrl.sv
module tb_i2c_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_go = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        rx_go = 1'b0;
    logic        rx_nack_sel = 1'b0;
    logic        bit_tick = 1'b0;
    logic [7:0]  rx_byte;
    logic        slave_nack;
    logic        sda_oe, scl_oe;
    logic        slave_pull = 1'b0;
    logic        glitch = 1'b0;
    logic        glitch_en = 1'b0;
    logic [3:0]  tick_cnt = '0;
    wire         sda_line = !(sda_oe || slave_pull);
    wire         scl_line = !scl_oe;

    int tests = 0;
    int fails = 0;
    int exp_q[$];

    logic       armed = 1'b0;
    logic       slave_rx = 1'b0;
    logic       slave_ack_low = 1'b1;
    logic [7:0] rx_src = '0;
    logic [8:0] shf = '0;
    int         bitcnt = 0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;

    always #2 clk = ~clk;

    i2c_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_go(tx_go), .tx_byte(tx_byte), .rx_go(rx_go),
        .rx_nack_sel(rx_nack_sel), .bit_tick(bit_tick), .rx_byte(rx_byte),
        .slave_nack(slave_nack), .sda_i(sda_line ^ glitch), .scl_i(scl_line ^ glitch),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // bit-rate enable and input glitch generator
    always @(negedge clk) begin
        tick_cnt <= tick_cnt + 1'b1;
        bit_tick <= (tick_cnt == 4'd14);
        glitch   <= glitch_en && (tick_cnt == 4'd11 || tick_cnt == 4'd12);
    end

    // scoreboard monitor: decodes bus events and compares with the queue
    task automatic mon_event(input int ev);
        string tag;
        tag = (ev >> 9) == 1 ? "R2" : (ev >> 9) == 2 ? "R7" : "R4/R5";
        if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL %s: actual 0x%0h expected no bus event", tag, ev);
        end else begin
            chk(tag, ev, exp_q.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && prev_scl && prev_sda && !sda_line) begin
                mon_event(1 << 9); bitcnt = 0;
            end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                mon_event(2 << 9); bitcnt = 0;
            end else if (scl_line && !prev_scl) begin
                shf = {shf[7:0], sda_line};
                bitcnt++;
                if (bitcnt == 9) begin
                    mon_event((3 << 9) | int'(shf));
                    bitcnt = 0;
                    armed = 1'b0;
                end
            end
            prev_scl = scl_line;
            prev_sda = sda_line;
            if (!scl_line) begin
                if (!armed) slave_pull = 1'b0;
                else if (slave_rx) slave_pull = (bitcnt < 8) ? !rx_src[7 - bitcnt] : 1'b0;
                else slave_pull = (bitcnt == 8) ? slave_ack_low : 1'b0;
            end
        end
    end

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic wait_bit(input int pos, input logic val);
        while (reg_rdata[pos] != val) @(negedge clk);
    endtask

    task automatic do_start;
        exp_q.push_back(1 << 9);
        wr(16'h0011);
        wait_bit(0, 1'b0);
        chk("R2 start bit self-clear", reg_rdata[0], 0);
        repeat (40) @(negedge clk);
        chk("R9 scl held low after start", scl_oe, 1);
    endtask

    task automatic send(input logic [7:0] b, input logic ack_low);
        slave_rx = 1'b0; slave_ack_low = ack_low; armed = 1'b1;
        exp_q.push_back((3 << 9) | (int'(b) << 1) | int'(!ack_low));
        @(negedge clk); tx_go = 1'b1; tx_byte = b;
        @(negedge clk); tx_go = 1'b0;
    endtask

    task automatic recv(input logic [7:0] b, input logic nack);
        slave_rx = 1'b1; rx_src = b; armed = 1'b1;
        exp_q.push_back((3 << 9) | (int'(b) << 1) | int'(nack));
        @(negedge clk); rx_go = 1'b1; rx_nack_sel = nack;
        @(negedge clk); rx_go = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset value", reg_rdata, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(16'hFFEC);
        chk("R1 reserved and busy bits read 0", reg_rdata, 16'h0000);
        wr(16'h0010);
        chk("R1 filter bit read back", reg_rdata, 16'h0010);
        chk("R9 bus released when idle", {sda_oe, scl_oe}, 0);

        do_start();
        chk("R3 busy flags 0 in wait", reg_rdata[9:8], 0);

        send(8'hA5, 1'b1);
        wait_bit(8, 1'b1);
        chk("R3 transmit busy set", reg_rdata[9:8], 2'b01);
        wait_bit(8, 1'b0);
        chk("R4 slave ack sampled", slave_nack, 0);
        chk("R9 scl low between bytes", scl_oe, 1);

        send(8'h3C, 1'b0);
        wait_bit(8, 1'b1);
        wait_bit(8, 1'b0);
        chk("R4 slave nack sampled", slave_nack, 1);

        do_start();
        glitch_en = 1'b1;
        recv(8'h96, 1'b0);
        wait_bit(9, 1'b1);
        chk("R3 receive busy set", reg_rdata[9:8], 2'b10);
        wait_bit(9, 1'b0);
        chk("R5 R8 received byte despite glitches", rx_byte, 8'h96);
        recv(8'h5B, 1'b1);
        wait_bit(9, 1'b1);
        wait_bit(9, 1'b0);
        glitch_en = 1'b0;
        chk("R5 received byte with nack", rx_byte, 8'h5B);

        send(8'h81, 1'b1);
        wait_bit(8, 1'b1);
        exp_q.push_back((3 << 9) | (8'h7E << 1));
        exp_q.push_back(2 << 9);
        wr(16'h0012);
        slave_ack_low = 1'b1;
        @(negedge clk); tx_go = 1'b1; tx_byte = 8'h7E;
        @(negedge clk); tx_go = 1'b0;
        wait_bit(8, 1'b0);
        armed = 1'b1;
        wait_bit(8, 1'b1);
        chk("R6 stop held pending during queued byte", reg_rdata[1], 1);
        wait_bit(8, 1'b0);
        wait_bit(1, 1'b0);
        chk("R7 bus released after stop", {sda_oe, scl_oe}, 0);
        repeat (100) @(negedge clk);
        chk("R6 all expected bus events seen", exp_q.size(), 0);
        summary();
    end
endmodule